// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps four bits of state for each of a parameterized number of external interrupt lines: enabled, pending, active, and the line level seen in the previous cycle. A line that goes from low to high becomes pending. A register bank behind a plain read/write strobe lets software set and clear enables and pending bits, read the active set, and pend any line by number through a software trigger word.

Priority arbitration sits outside the block. It sees the per-line `irq_ready` vector, which is pending AND enabled. When the core takes an interrupt, it strobes an acknowledge with the winning line. When the handler returns, it strobes a completion with the line number. The block flags a completion that does not match an active line. If the input is still high when its handler completes, the line is pended again, so a level-held source keeps being serviced. The `ret_base` output is high when zero or one handler is active, so the core can tell whether a return leaves it at base level.

Top module: `irq_tracker`

## Requirements
- R1: After reset, every enable, pending and active bit is 0, `irq_ready` and `irq_active` are all zero, `ret_base` is 1, and `rd_data` is 0.
- R2: When a line goes from low to high (between the previous cycle and this one), its pending bit is 1 after the clock edge. A line held high does not pend again. A one-cycle pulse pends the line once.
- R3: An acknowledge of line L takes effect only if L is both pending and enabled. It then clears pending[L] and sets active[L] at the edge. In any other case the acknowledge changes nothing.
- R4: A completion of an active line L clears active[L]. If `irq_in[L]` is high in the completion cycle, pending[L] is set again at the same edge.
- R5: A completion of a line that is not active, or whose number is at or above NUM_LINES, drives `cpl_illegal` high in that same cycle and changes no state.
- R6: `ret_base` is 1 when no line or exactly one line is active, and 0 when two or more are active.
- R7: Addressing uses a word address {region[2:0], word[2:0]}. Bit b of word w stands for line 32*w+b, which is exception number 32*w+b+16. In region 0 (set-enable) a written 1 sets the enable bit. In region 1 (clear-enable) a written 1 clears it. A written 0 has no effect, and both regions read back the enable bits.
- R8: Region 2 (set-pending) and region 3 (clear-pending) follow the same write-1 rule for pending bits, and both read back the pending bits.
- R9: Region 4 reads back the active bits. Writes to it change nothing.
- R10: A write to region 5 (software trigger) pends line wdata[8:0], which is exception number wdata[8:0]+16. Higher data bits are ignored. The write has no effect when wdata[8:0] >= NUM_LINES. Region 5 reads as zero.
- R11: Bits that address a line at or above NUM_LINES read as 0, and writes to them are ignored.
- R12: In a single cycle, a clear-pending bit overrides every source that would set the same pending bit: a rising edge, a set-pending write, a software trigger, or a re-pend on completion.
- R13: `irq_ready` equals pending AND enabled for each line. `irq_active` equals the active bits.
- R14: A read strobe captures the addressed word, and the value appears on `rd_data` in the following cycle. `rd_data` holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | External interrupt line levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address {region, word} |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| ack_valid | input | 1 | Acknowledge strobe from the core |
| ack_line | input | LINE_W | Line being acknowledged |
| cpl_valid | input | 1 | Handler completion strobe |
| cpl_line | input | LINE_W | Line being completed |
| cpl_illegal | output | 1 | Completion does not match an active line |
| ret_base | output | 1 | At most one handler active |
| irq_ready | output | NUM_LINES | Pending and enabled, per line |
| irq_active | output | NUM_LINES | Active bits |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of bug:
- A pulse that drops before acknowledge must still be serviced. A level-sensitive design would lose it.
- A line held high through completion must re-pend. A design that only detects edges would service it once and stop.
- A clear-pending write in the same cycle as a rising edge must win. A design with the wrong precedence would leave a stale pending bit.
- Acknowledges of unpending or disabled lines, completions of inactive or out-of-range lines, the upper word's bits above the line count, and software-trigger values at and beyond the line count must all leave state untouched.
- The base-level flag is checked through nesting depths of zero, one and two. A miscount would show up as a wrong `ret_base`.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int MAX_WORDS = 8;
    localparam int TRIG_W   = 9;

    typedef enum logic [2:0] {
        RGN_SET_EN   = 3'd0,
        RGN_CLR_EN   = 3'd1,
        RGN_SET_PEND = 3'd2,
        RGN_CLR_PEND = 3'd3,
        RGN_ACTIVE   = 3'd4,
        RGN_SW_TRIG  = 3'd5
    } region_e;
endpackage

// File: rtl/irq_trk_edge.sv
module irq_trk_edge #(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] rise
);
    typedef struct packed {
        logic [NUM_LINES-1:0] level;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = irq_in;
        rise       = irq_in & ~st_q.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_trk_decode.sv
module irq_trk_decode
    import irq_trk_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] pend_q,
    input  logic [NUM_LINES-1:0] act_q,
    output logic [NUM_LINES-1:0] set_en,
    output logic [NUM_LINES-1:0] clr_en,
    output logic [NUM_LINES-1:0] set_pend,
    output logic [NUM_LINES-1:0] clr_pend,
    output logic [NUM_LINES-1:0] sw_pend,
    output logic [WORD_W-1:0]    rd_data
);
    localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_st_t;

    rd_st_t              rd_d, rd_q;
    region_e             region;
    logic [2:0]          wsel;
    logic [PAD_W-1:0]    wmask;
    logic [PAD_W-1:0]    src;
    logic [WORD_W-1:0]   rd_word;
    logic [TRIG_W-1:0]   trig_idx;

    always_comb begin
        region   = region_e'(addr[5:3]);
        wsel     = addr[2:0];
        trig_idx = wdata[TRIG_W-1:0];

        wmask = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (wsel == 3'(w)) wmask[w*WORD_W +: WORD_W] = wdata;
        end

        set_en   = (wr_en && region == RGN_SET_EN)   ? wmask[NUM_LINES-1:0] : '0;
        clr_en   = (wr_en && region == RGN_CLR_EN)   ? wmask[NUM_LINES-1:0] : '0;
        set_pend = (wr_en && region == RGN_SET_PEND) ? wmask[NUM_LINES-1:0] : '0;
        clr_pend = (wr_en && region == RGN_CLR_PEND) ? wmask[NUM_LINES-1:0] : '0;

        sw_pend = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            sw_pend[i] = wr_en && (region == RGN_SW_TRIG) && (trig_idx == TRIG_W'(i));
        end

        src = '0;
        unique case (region)
            RGN_SET_EN, RGN_CLR_EN:     src[NUM_LINES-1:0] = en_q;
            RGN_SET_PEND, RGN_CLR_PEND: src[NUM_LINES-1:0] = pend_q;
            RGN_ACTIVE:                 src[NUM_LINES-1:0] = act_q;
            default:                    src = '0;
        endcase

        rd_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (wsel == 3'(w)) rd_word = src[w*WORD_W +: WORD_W];
        end

        rd_d = rd_q;
        if (rd_en) rd_d.data = rd_word;
        rd_data = rd_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // R10: a software trigger pends at most one line per write
    a_r10_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_pend));
endmodule

// File: rtl/irq_trk_state.sv
module irq_trk_state #(
    parameter int NUM_LINES = 40,
    parameter int LINE_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] rise,
    input  logic [NUM_LINES-1:0] set_en,
    input  logic [NUM_LINES-1:0] clr_en,
    input  logic [NUM_LINES-1:0] set_pend,
    input  logic [NUM_LINES-1:0] clr_pend,
    input  logic [NUM_LINES-1:0] sw_pend,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    input  logic                 cpl_valid,
    input  logic [LINE_W-1:0]    cpl_line,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] act_q,
    output logic                 cpl_illegal,
    output logic                 ret_base
);
    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] act;
    } vec_st_t;

    vec_st_t              st_d, st_q;
    logic [NUM_LINES-1:0] ack_mask;
    logic [NUM_LINES-1:0] cpl_mask;
    logic [NUM_LINES-1:0] rearm;
    logic [NUM_LINES-1:0] pend_set;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            ack_mask[i] = ack_valid && (ack_line == LINE_W'(i)) && st_q.pend[i] && st_q.en[i];
            cpl_mask[i] = cpl_valid && (cpl_line == LINE_W'(i)) && st_q.act[i];
        end
        cpl_illegal = cpl_valid && (cpl_mask == '0);
        rearm       = cpl_mask & irq_in;
        pend_set    = rise | set_pend | sw_pend | rearm;

        st_d      = st_q;
        st_d.en   = (st_q.en | set_en) & ~clr_en;
        st_d.pend = ((st_q.pend & ~ack_mask) | pend_set) & ~clr_pend;
        st_d.act  = (st_q.act & ~cpl_mask) | ack_mask;

        ret_base = ((st_q.act & (st_q.act - NUM_LINES'(1))) == '0);
        en_q     = st_q.en;
        pend_q   = st_q.pend;
        act_q    = st_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: an accepted acknowledge leaves its line active
    a_r3_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mask != '0) |=> ((act_q & $past(ack_mask)) == $past(ack_mask)));

    // R12: clear-pending beats every set source in the same cycle
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend != '0) |=> ((pend_q & $past(clr_pend)) == '0));

    // R2: an edge not cleared in the same cycle lands in pending
    a_r2_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~clr_pend) != '0) |=>
        ((pend_q & $past(rise & ~clr_pend)) == $past(rise & ~clr_pend)));

    // R5: an illegal completion leaves the active set untouched
    a_r5_illegal_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_illegal && ack_mask == '0) |=> (act_q == $past(act_q)));

    // R6: base flag against nesting depth
    a_r6_base_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_q) |-> ret_base);
    a_r6_base_nested: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot0(act_q) |-> !ret_base);
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
    import irq_trk_pkg::*;
#(
    parameter int NUM_LINES = 40,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rd_data,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    input  logic                 cpl_valid,
    input  logic [LINE_W-1:0]    cpl_line,
    output logic                 cpl_illegal,
    output logic                 ret_base,
    output logic [NUM_LINES-1:0] irq_ready,
    output logic [NUM_LINES-1:0] irq_active
);
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] set_en, clr_en, set_pend, clr_pend, sw_pend;
    logic [NUM_LINES-1:0] en_q, pend_q, act_q;

    irq_trk_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
    );

    irq_trk_decode #(.NUM_LINES(NUM_LINES)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
        .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend),
        .clr_pend(clr_pend), .sw_pend(sw_pend), .rd_data(rd_data)
    );

    irq_trk_state #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_st (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise),
        .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend),
        .clr_pend(clr_pend), .sw_pend(sw_pend),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .cpl_valid(cpl_valid), .cpl_line(cpl_line),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
        .cpl_illegal(cpl_illegal), .ret_base(ret_base)
    );

    assign irq_ready  = pend_q & en_q;
    assign irq_active = act_q;
endmodule

// File: tb/sim_irq_tracker.sv
module sim_irq_tracker;
    localparam int N          = 40;
    localparam int LW         = 6;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  irq_in;
    logic          wr_en, rd_en;
    logic [5:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rd_data;
    logic          ack_valid, cpl_valid;
    logic [LW-1:0] ack_line, cpl_line;
    logic          cpl_illegal, ret_base;
    logic [N-1:0]  irq_ready, irq_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_en, m_pend, m_act, m_prev;
    logic [31:0]  m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_tracker #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .cpl_valid(cpl_valid), .cpl_line(cpl_line),
        .cpl_illegal(cpl_illegal), .ret_base(ret_base),
        .irq_ready(irq_ready), .irq_active(irq_active)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] fn_word(input logic [2:0] w, input logic [31:0] d);
        logic [255:0] t = '0;
        t[w*32 +: 32] = d;
        return t[N-1:0];
    endfunction

    function automatic logic [31:0] fn_read(input logic [5:0] a);
        logic [255:0] s = '0;
        case (a[5:3])
            3'd0, 3'd1: s[N-1:0] = m_en;
            3'd2, 3'd3: s[N-1:0] = m_pend;
            3'd4:       s[N-1:0] = m_act;
            default:    s = '0;
        endcase
        return s[a[2:0]*32 +: 32];
    endfunction

    function automatic logic fn_base(input logic [N-1:0] a);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(a[i]);
        return c <= 1;
    endfunction

    function automatic logic fn_illegal();
        if (!cpl_valid) return 1'b0;
        if (int'(cpl_line) >= N) return 1'b1;
        return !m_act[cpl_line];
    endfunction

    task automatic m_update();
        logic [N-1:0] rise, se, ce, sp, cp, sw, am, cm, ra;
        rise = irq_in & ~m_prev;
        se = '0; ce = '0; sp = '0; cp = '0; sw = '0; am = '0; cm = '0;
        if (wr_en) begin
            case (addr[5:3])
                3'd0: se = fn_word(addr[2:0], wdata);
                3'd1: ce = fn_word(addr[2:0], wdata);
                3'd2: sp = fn_word(addr[2:0], wdata);
                3'd3: cp = fn_word(addr[2:0], wdata);
                3'd5: if (int'(wdata[8:0]) < N) sw[wdata[8:0]] = 1'b1;
                default: ;
            endcase
        end
        if (ack_valid && int'(ack_line) < N && m_pend[ack_line] && m_en[ack_line]) am[ack_line] = 1'b1;
        if (cpl_valid && int'(cpl_line) < N && m_act[cpl_line]) cm[cpl_line] = 1'b1;
        ra     = cm & irq_in;
        m_en   = (m_en | se) & ~ce;
        m_pend = ((m_pend & ~am) | rise | sp | sw | ra) & ~cp;
        m_act  = (m_act & ~cm) | am;
        m_prev = irq_in;
    endtask

    // one clock: check combinational outputs, advance model, check read port
    task automatic step();
        logic        was_rd;
        logic [31:0] exp_rd;
        #1;
        chk(irq_ready == (m_pend & m_en), "R13 ready", 64'(irq_ready), 64'(m_pend & m_en));
        chk(irq_active == m_act, "R3/R4 active", 64'(irq_active), 64'(m_act));
        chk(ret_base == fn_base(m_act), "R6 ret_base", 64'(ret_base), 64'(fn_base(m_act)));
        chk(cpl_illegal == fn_illegal(), "R5 cpl_illegal", 64'(cpl_illegal), 64'(fn_illegal()));
        was_rd = rd_en;
        exp_rd = rd_en ? fn_read(addr) : m_rd;
        @(posedge clk);
        m_update();
        @(negedge clk);
        m_rd = exp_rd;
        chk(rd_data == exp_rd, was_rd ? "R14 read data" : "R14 hold", 64'(rd_data), 64'(exp_rd));
        wr_en = 1'b0; rd_en = 1'b0; ack_valid = 1'b0; cpl_valid = 1'b0;
    endtask

    task automatic do_wr(input logic [2:0] rgn, input logic [2:0] w, input logic [31:0] d);
        wr_en = 1'b1; addr = {rgn, w}; wdata = d;
        step();
    endtask

    task automatic do_rd(input logic [2:0] rgn, input logic [2:0] w);
        rd_en = 1'b1; addr = {rgn, w};
        step();
    endtask

    task automatic do_ack(input int l);
        ack_valid = 1'b1; ack_line = LW'(l);
        step();
    endtask

    task automatic do_cpl(input int l);
        cpl_valid = 1'b1; cpl_line = LW'(l);
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0; irq_in = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        ack_valid = 0; cpl_valid = 0; ack_line = '0; cpl_line = '0;
        m_en = '0; m_pend = '0; m_act = '0; m_prev = '0; m_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(irq_ready == '0 && irq_active == '0, "R1 vectors", 64'(irq_active), 64'd0);
        chk(ret_base == 1'b1, "R1 ret_base", 64'(ret_base), 64'd1);
        chk(rd_data == '0, "R1 rd_data", 64'(rd_data), 64'd0);
        @(negedge clk);
        do_rd(3'd0, 3'd0); do_rd(3'd2, 3'd1); do_rd(3'd4, 3'd0);

        // R7: set/clear enable, both addresses read back
        do_wr(3'd0, 3'd0, 32'hF0F0_00FF);
        do_rd(3'd0, 3'd0); do_rd(3'd1, 3'd0);
        do_wr(3'd1, 3'd0, 32'h0000_000F);
        do_rd(3'd1, 3'd0);
        chk(rd_data == 32'hF0F0_00F0, "R7 clear-enable", 64'(rd_data), 64'hF0F0_00F0);
        do_wr(3'd0, 3'd0, 32'h0000_0FFF);

        // R11: bits past the line count read zero
        do_wr(3'd0, 3'd1, 32'hFFFF_FFFF);
        do_rd(3'd0, 3'd1);
        chk(rd_data == 32'h0000_00FF, "R11 upper word", 64'(rd_data), 64'hFF);
        do_rd(3'd0, 3'd2);
        chk(rd_data == 32'h0, "R11 absent word", 64'(rd_data), 64'h0);

        // R2: held level pends once; clearing while high stays clear; pulse pends
        irq_in[3] = 1'b1; step(); step();
        do_wr(3'd3, 3'd0, 32'h8); step();
        do_rd(3'd2, 3'd0);
        chk(rd_data[3] == 1'b0, "R2 held high no re-pend", 64'(rd_data[3]), 64'd0);
        irq_in[3] = 1'b0;
        irq_in[5] = 1'b1; step(); irq_in[5] = 1'b0; step(); step();
        chk(irq_ready[5] == 1'b1, "R2 pulse pends", 64'(irq_ready[5]), 64'd1);

        // R12: clear-pending write beats a rising edge in the same cycle
        irq_in[7] = 1'b1; do_wr(3'd3, 3'd0, 32'h80);
        chk(irq_ready[7] == 1'b0, "R12 clear wins", 64'(irq_ready[7]), 64'd0);
        irq_in[7] = 1'b0; step();

        // R3: accepted and ignored acknowledges
        do_ack(5);
        chk(irq_active[5] && !irq_ready[5], "R3 ack", 64'(irq_active), 64'h20);
        do_ack(9);
        chk(irq_active[9] == 1'b0, "R3 ack not pending", 64'(irq_active[9]), 64'd0);
        do_wr(3'd2, 3'd0, 32'h0001_0000);
        do_ack(16);
        chk(irq_active[16] == 1'b0, "R3 ack disabled", 64'(irq_active[16]), 64'd0);

        // R6: nesting two deep clears the base flag
        do_wr(3'd2, 3'd0, 32'h40);
        do_ack(6);
        chk(ret_base == 1'b0, "R6 two active", 64'(ret_base), 64'd0);
        do_cpl(6); do_cpl(5);

        // R4: completion while high re-pends; low does not
        irq_in[10] = 1'b1; step();
        do_ack(10); do_cpl(10);
        chk(irq_ready[10] && !irq_active[10], "R4 re-pend", 64'(irq_ready[10]), 64'd1);
        irq_in[10] = 1'b0;
        do_ack(10); do_cpl(10);
        chk(!irq_ready[10] && !irq_active[10], "R4 no re-pend", 64'(irq_ready[10]), 64'd0);

        // R5: illegal completions
        do_cpl(20); do_cpl(45);

        // R10: software trigger
        do_wr(3'd5, 3'd0, 32'd33);
        do_wr(3'd5, 3'd0, 32'd40);
        do_wr(3'd5, 3'd0, 32'h0000_0202);
        do_rd(3'd2, 3'd1);
        chk(rd_data == 32'h2, "R10 trigger line 33", 64'(rd_data), 64'h2);
        do_rd(3'd3, 3'd0);
        chk(rd_data[2] == 1'b1, "R10 upper bits ignored", 64'(rd_data[2]), 64'd1);
        do_rd(3'd5, 3'd0);

        // R9: active region ignores writes
        do_wr(3'd4, 3'd0, 32'hFFFF_FFFF);
        do_rd(3'd4, 3'd0);
        chk(rd_data == 32'h0, "R9 active read-only", 64'(rd_data), 64'h0);

        // R8: pending set/clear via both addresses
        do_wr(3'd2, 3'd1, 32'hFFFF_FF00);
        do_rd(3'd3, 3'd1);
        do_wr(3'd3, 3'd1, 32'hFFFF_FFFF);
        do_rd(3'd2, 3'd1);
        chk(rd_data == 32'h0, "R8 clear-pending", 64'(rd_data), 64'h0);

        // constrained random traffic against the model
        for (int it = 0; it < 4000; it++) begin
            for (int b = 0; b < N; b++) if ($urandom % 12 == 0) irq_in[b] = ~irq_in[b];
            case ($urandom % 8)
                0: begin
                    wr_en = 1'b1;
                    addr  = {3'($urandom % 6), 3'($urandom % 3)};
                    wdata = (addr[5:3] == 3'd5) ? 32'($urandom % 48) : $urandom;
                end
                1: begin rd_en = 1'b1; addr = {3'($urandom % 6), 3'($urandom % 3)}; end
                2, 3: begin
                    int s = int'($urandom % N);
                    ack_valid = 1'b1; ack_line = LW'($urandom % 48);
                    for (int k = 0; k < N; k++) begin
                        int j = (s + k) % N;
                        if (m_pend[j] && m_en[j]) begin ack_line = LW'(j); break; end
                    end
                end
                4: begin
                    int s = int'($urandom % N);
                    cpl_valid = 1'b1; cpl_line = LW'($urandom % 48);
                    if ($urandom % 4 != 0)
                        for (int k = 0; k < N; k++) begin
                            int j = (s + k) % N;
                            if (m_act[j]) begin cpl_line = LW'(j); break; end
                        end
                end
                default: ;
            endcase
            step();
        end
        for (int r = 0; r < 6; r++)
            for (int w = 0; w < 3; w++) do_rd(3'(r), 3'(w));

        finish_run();
    end
endmodule